// File: doc/BRIEF.md
# DRAM Node Range Decoder

This block decides which memory node owns a physical system address. It holds eight programmable address windows. Each window has a base, a limit, an enable field, a destination node number and node-interleave settings. It also holds, for each node, a hoisting-hole setting and a swapped-region setting. A caller pulses `start_i` with an address. The block then checks the windows one per clock, lowest index first. When the first matching window is found, or the last window has been checked, it pulses `done_o` for one cycle. The results it presents are the node, the number of address bits that node interleaving consumes, the address after the swapped-region transform, and flags for hit, bounds error and bad interleave mask.

Two rules act after a window matches. An address that falls in the owning node's hoisting hole below 4 GiB has no DRAM behind it, so it is reported as a bounds error. A low address inside the owning node's swapped region is XORed with that region's base before it is presented.

A write port loads the configuration. `cfg_kind_i` selects the register kind, `cfg_idx_i` selects the window or node, and `cfg_wdata_i` carries the 32-bit value.

Top module: `dnr_node_decoder`

## Requirements
- R1: Register kinds are selected by `cfg_kind_i`, indexed by `cfg_idx_i`:
  - 0: window base low word. Enable in bits [1:0], interleave mask in [10:8], address bits [39:24] in [31:16].
  - 1: window base high word. Address bits [47:40] in [7:0].
  - 2: window limit low word. Node in [2:0], interleave select in [10:8], limit bits [39:24] in [31:16].
  - 3: window limit high word. Limit bits [47:40] in [7:0].
  - 4: node hole word. Valid in bit 0, hole base bits [31:24] in [31:24].
  - 5: node swap word. Enable in bit 0, region base in [14:8], region limit in [22:16], region size in [30:24]. Region values are in units of address bits [33:27].
- R2: A window matches only when three conditions hold. Its enable field is nonzero. The address is at or above the base, whose bits [23:0] are zero. The address is at or below the limit, whose bits [23:0] are all ones.
- R3: A window with a nonzero interleave mask matches only if its interleave select equals address bits [14:12] ANDed with the mask. A zero mask skips this test.
- R4: On a match, `ilog_o` is 0, 1, 2 or 3 for masks 0, 1, 3 or 7. Any other mask gives `ilog_o` = 0 and `cfg_err_o` = 1.
- R5: Windows are checked in ascending index order and the first match wins. A match at window k raises `done_o` k+1 cycles after the edge that samples `start_i`. The reported node is taken from that window's limit word.
- R6: If no window matches, `done_o` rises 8 cycles after the sampling edge with `hit_o` = 0, `bounds_err_o` = 1 and `xaddr_o` equal to the input address.
- R7: If the owning node's hole is valid and the address is at or above the hole base and below 4 GiB, the result is `hit_o` = 0 and `bounds_err_o` = 1.
- R8: The swap transform applies when the owning node's swap is enabled, address bits [47:34] are zero, and address bits [33:27] are either within region base..limit or below region size. In that case `xaddr_o` is the address XOR (region base << 27). In every other case `xaddr_o` equals the address.
- R9: `done_o` is high for exactly one cycle per scan. A `start_i` that arrives while a scan is running is ignored, along with its address.
- R10: After reset, all outputs are zero and every window is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_kind_i | input | 3 | Register kind (see R1) |
| cfg_idx_i | input | 3 | Window or node index |
| cfg_wdata_i | input | 32 | Write data |
| start_i | input | 1 | Start a lookup |
| addr_i | input | 48 | System address, sampled with start_i |
| done_o | output | 1 | One-cycle result strobe |
| hit_o | output | 1 | Address maps to DRAM on a node |
| node_o | output | 3 | Owning node |
| ilog_o | output | 2 | Node-interleave bit count |
| xaddr_o | output | 48 | Address after swap transform |
| bounds_err_o | output | 1 | No DRAM target for the address |
| cfg_err_o | output | 1 | Owning window has an invalid interleave mask |

## Verification
The bench places overlapping windows so that a later window also matches. A design that does not stop at the first match would report the later window's node and take longer to finish. Addresses are placed exactly on a limit and just inside the hoisting hole, which exposes off-by-one comparisons: a hole address would come back as a hit. Interleaved windows are told apart only by address bit 12. A wrong bit choice or a missing AND with the mask routes those lookups to the wrong node. The swap tests use an address above 2^34 inside an enabled region, which catches a transform that ignores the high-bit rule. They also use an address just under the region size, which catches a transform that only checks the base..limit window. A second start during a scan checks that the latched address is not overwritten.

// File: rtl/dnr_pkg.sv
package dnr_pkg;
  localparam int ADDR_W = 48;
  localparam int NODE_W = 3;
  localparam int NUM_NODES = 1 << NODE_W;

  typedef enum logic [2:0] {
    CFG_BASE_LO = 3'd0,
    CFG_BASE_HI = 3'd1,
    CFG_LIM_LO  = 3'd2,
    CFG_LIM_HI  = 3'd3,
    CFG_HOLE    = 3'd4,
    CFG_SWAP    = 3'd5
  } cfg_kind_e;

  typedef struct packed {
    logic       ok;
    logic [1:0] lg;
  } ilog_t;

  // Interleave mask to consumed-bit count; only contiguous low masks are legal
  function automatic ilog_t mask_to_ilog(input logic [2:0] mask);
    ilog_t r;
    case (mask)
      3'b000:  r = '{ok: 1'b1, lg: 2'd0};
      3'b001:  r = '{ok: 1'b1, lg: 2'd1};
      3'b011:  r = '{ok: 1'b1, lg: 2'd2};
      3'b111:  r = '{ok: 1'b1, lg: 2'd3};
      default: r = '{ok: 1'b0, lg: 2'd0};
    endcase
    return r;
  endfunction
endpackage

// File: rtl/dnr_cfg_regs.sv
module dnr_cfg_regs
  import dnr_pkg::*;
#(
  parameter int NUM_RANGES = 8,
  parameter int IDX_W = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [2:0]           kind,
  input  logic [IDX_W-1:0]     widx,
  input  logic [31:0]          wdata,
  input  logic [IDX_W-1:0]     rng_idx,
  output logic [31:0]          base_lo,
  output logic [7:0]           base_hi,
  output logic [31:0]          lim_lo,
  output logic [7:0]           lim_hi,
  input  logic [NODE_W-1:0]    node_idx,
  output logic [31:0]          hole_w,
  output logic [31:0]          swap_w
);
  logic [31:0] base_lo_q [NUM_RANGES];
  logic [7:0]  base_hi_q [NUM_RANGES];
  logic [31:0] lim_lo_q  [NUM_RANGES];
  logic [7:0]  lim_hi_q  [NUM_RANGES];
  logic [31:0] hole_q    [NUM_NODES];
  logic [31:0] swap_q    [NUM_NODES];

  // Window storage: reset clears the enable field of every window
  genvar g;
  generate
    for (g = 0; g < NUM_RANGES; g++) begin : g_rng
      always_ff @(posedge clk) begin
        if (rst) begin
          base_lo_q[g] <= '0;
          base_hi_q[g] <= '0;
          lim_lo_q[g]  <= '0;
          lim_hi_q[g]  <= '0;
        end else if (we && widx == IDX_W'(g)) begin
          case (kind)
            CFG_BASE_LO: base_lo_q[g] <= wdata;
            CFG_BASE_HI: base_hi_q[g] <= wdata[7:0];
            CFG_LIM_LO:  lim_lo_q[g]  <= wdata;
            CFG_LIM_HI:  lim_hi_q[g]  <= wdata[7:0];
            default: ;
          endcase
        end
      end
    end
    for (g = 0; g < NUM_NODES; g++) begin : g_node
      always_ff @(posedge clk) begin
        if (rst) begin
          hole_q[g] <= '0;
          swap_q[g] <= '0;
        end else if (we && widx[NODE_W-1:0] == NODE_W'(g)) begin
          if (kind == CFG_HOLE) hole_q[g] <= wdata;
          if (kind == CFG_SWAP) swap_q[g] <= wdata;
        end
      end
    end
  endgenerate

  assign base_lo = base_lo_q[rng_idx];
  assign base_hi = base_hi_q[rng_idx];
  assign lim_lo  = lim_lo_q[rng_idx];
  assign lim_hi  = lim_hi_q[rng_idx];
  assign hole_w  = hole_q[node_idx];
  assign swap_w  = swap_q[node_idx];
endmodule

// File: rtl/dnr_range_match.sv
module dnr_range_match
  import dnr_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       base_lo,
  input  logic [7:0]        base_hi,
  input  logic [31:0]       lim_lo,
  input  logic [7:0]        lim_hi,
  output logic              hit,
  output logic [NODE_W-1:0] node,
  output logic [2:0]        mask
);
  logic [ADDR_W-1:0] base_a, lim_a;
  logic [2:0]        sel;
  logic              en, in_win, ilv_ok;

  always_comb begin
    base_a = {base_hi, base_lo[31:16], 24'h000000};
    lim_a  = {lim_hi, lim_lo[31:16], 24'hFFFFFF};
    en     = |base_lo[1:0];
    mask   = base_lo[10:8];
    sel    = lim_lo[10:8];
    node   = lim_lo[NODE_W-1:0];
    in_win = (addr >= base_a) && (addr <= lim_a);
    ilv_ok = (mask == 3'b000) || (sel == (addr[14:12] & mask));
    hit    = en && in_win && ilv_ok;
  end
endmodule

// File: rtl/dnr_hole_swap.sv
module dnr_hole_swap
  import dnr_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       hole_w,
  input  logic [31:0]       swap_w,
  output logic              in_hole,
  output logic [ADDR_W-1:0] xaddr
);
  logic [ADDR_W-1:0] hole_base;
  logic [6:0]        seg, r_base, r_lim, r_size;
  logic              low_only, in_rgn;

  always_comb begin
    hole_base = {{(ADDR_W-32){1'b0}}, hole_w[31:24], 24'h000000};
    in_hole   = hole_w[0] && (addr >= hole_base) && (addr[ADDR_W-1:32] == '0);
    seg       = addr[33:27];
    r_base    = swap_w[14:8];
    r_lim     = swap_w[22:16];
    r_size    = swap_w[30:24];
    low_only  = (addr[ADDR_W-1:34] == '0);
    in_rgn    = ((seg >= r_base) && (seg <= r_lim)) || (seg < r_size);
    xaddr     = addr;
    if (swap_w[0] && low_only && in_rgn)
      xaddr[33:27] = seg ^ r_base;
  end
endmodule

// File: rtl/dnr_node_decoder.sv
module dnr_node_decoder
  import dnr_pkg::*;
#(
  parameter int NUM_RANGES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_kind_i,
  input  logic [2:0]        cfg_idx_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic              start_i,
  input  logic [47:0]       addr_i,
  output logic              done_o,
  output logic              hit_o,
  output logic [2:0]        node_o,
  output logic [1:0]        ilog_o,
  output logic [47:0]       xaddr_o,
  output logic              bounds_err_o,
  output logic              cfg_err_o
);
  localparam int IDX_W = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_RANGES - 1);

  logic              busy;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] addr_q;

  logic [31:0]       base_lo, lim_lo, hole_w, swap_w;
  logic [7:0]        base_hi, lim_hi;
  logic              m_hit, in_hole;
  logic [NODE_W-1:0] m_node;
  logic [2:0]        m_mask;
  logic [ADDR_W-1:0] sw_addr;
  ilog_t             il;

  dnr_cfg_regs #(.NUM_RANGES(NUM_RANGES), .IDX_W(IDX_W)) regs_i (
    .clk(clk), .rst(rst), .we(cfg_we_i), .kind(cfg_kind_i),
    .widx(IDX_W'(cfg_idx_i)), .wdata(cfg_wdata_i),
    .rng_idx(idx), .base_lo(base_lo), .base_hi(base_hi),
    .lim_lo(lim_lo), .lim_hi(lim_hi),
    .node_idx(m_node), .hole_w(hole_w), .swap_w(swap_w)
  );

  dnr_range_match match_i (
    .addr(addr_q), .base_lo(base_lo), .base_hi(base_hi),
    .lim_lo(lim_lo), .lim_hi(lim_hi),
    .hit(m_hit), .node(m_node), .mask(m_mask)
  );

  dnr_hole_swap hs_i (
    .addr(addr_q), .hole_w(hole_w), .swap_w(swap_w),
    .in_hole(in_hole), .xaddr(sw_addr)
  );

  assign il = mask_to_ilog(m_mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy         <= 1'b0;
      idx          <= '0;
      addr_q       <= '0;
      done_o       <= 1'b0;
      hit_o        <= 1'b0;
      node_o       <= '0;
      ilog_o       <= '0;
      xaddr_o      <= '0;
      bounds_err_o <= 1'b0;
      cfg_err_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!busy) begin
        if (start_i) begin
          busy   <= 1'b1;
          idx    <= '0;
          addr_q <= addr_i;
        end
      end else if (m_hit) begin
        busy         <= 1'b0;
        done_o       <= 1'b1;
        node_o       <= m_node;
        ilog_o       <= il.lg;
        cfg_err_o    <= !il.ok;
        hit_o        <= !in_hole;
        bounds_err_o <= in_hole;
        xaddr_o      <= in_hole ? addr_q : sw_addr;
      end else if (idx == LAST_IDX) begin
        busy         <= 1'b0;
        done_o       <= 1'b1;
        node_o       <= '0;
        ilog_o       <= '0;
        cfg_err_o    <= 1'b0;
        hit_o        <= 1'b0;
        bounds_err_o <= 1'b1;
        xaddr_o      <= addr_q;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  // R9: result strobe lasts one cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R9: a start during a scan leaves the latched address alone
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && start_i) |=> (addr_q == $past(addr_q)));
  // R5: a result only follows a running scan
  a_r5_done_after_scan: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(busy));
  // R7: a hole result never also claims a hit
  a_r7_hit_excl: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !(hit_o && bounds_err_o));
  // R4: an illegal mask reports zero consumed bits
  a_r4_bad_mask_ilog: assert property (@(posedge clk) disable iff (rst)
    (done_o && cfg_err_o) |-> (ilog_o == 2'd0));
endmodule

// File: tb/dnr_node_decoder_tb.sv
module dnr_node_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [2:0]  cfg_kind, cfg_idx;
  logic [31:0] cfg_wdata;
  logic        start;
  logic [47:0] addr;
  logic        done, hit, bounds_err, cfg_err;
  logic [2:0]  node;
  logic [1:0]  ilog;
  logic [47:0] xaddr;

  int checks = 0;
  int fails = 0;
  int cyc;
  bit finished = 0;

  always #2 clk = ~clk;

  dnr_node_decoder dut_i (
    .clk(clk), .rst(rst), .cfg_we_i(cfg_we), .cfg_kind_i(cfg_kind),
    .cfg_idx_i(cfg_idx), .cfg_wdata_i(cfg_wdata), .start_i(start),
    .addr_i(addr), .done_o(done), .hit_o(hit), .node_o(node),
    .ilog_o(ilog), .xaddr_o(xaddr), .bounds_err_o(bounds_err),
    .cfg_err_o(cfg_err)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] k, input logic [2:0] i, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_kind = k; cfg_idx = i; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic prog(input int i, input logic [47:0] b, input logic [47:0] l,
                      input logic [1:0] en, input logic [2:0] mask,
                      input logic [2:0] sel, input logic [2:0] nd);
    wr(3'd0, 3'(i), {b[39:24], 5'b0, mask, 6'b0, en});
    wr(3'd1, 3'(i), {24'b0, b[47:40]});
    wr(3'd2, 3'(i), {l[39:24], 5'b0, sel, 5'b0, nd});
    wr(3'd3, 3'(i), {24'b0, l[47:40]});
  endtask

  // Launch a lookup; cyc counts negedges until done, strobe width checked
  task automatic scan(input logic [47:0] a, input bit poke);
    @(negedge clk);
    start = 1'b1; addr = a;
    @(negedge clk);
    start = 1'b0; addr = '0;
    cyc = 0;
    while (!done && cyc < 40) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 2) begin start = 1'b1; addr = 48'h1_0000_0000; end
      else start = 1'b0;
    end
    start = 1'b0;
  endtask

  task automatic strobe_drop(input string req);
    logic h; logic [2:0] n;
    h = hit; n = node;
    @(negedge clk);
    chk(req, done, 0);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(req, done, 0);
    end
    chk(req, {hit, node}, {h, n});
  endtask

  task automatic t_reset();
    chk("R10 done", done, 0);
    chk("R10 outputs", {hit, node, ilog, xaddr, bounds_err, cfg_err}, 0);
    scan(48'h0, 0);
    chk("R10 all windows off latency", cyc, 8);
    chk("R10 miss", {hit, bounds_err}, 2'b01);
  endtask

  task automatic t_basic();
    scan(48'h1_8000_0000, 0);
    chk("R5 first hit node", node, 2);
    chk("R5 first hit latency", cyc, 1);
    chk("R2 hit", {hit, bounds_err, cfg_err, ilog}, 5'b10000);
    chk("R8 high address untouched", xaddr, 48'h1_8000_0000);
    strobe_drop("R9 strobe width");
    scan(48'h1_FFFF_FFFF, 0);
    chk("R2 limit inclusive", {hit, node}, {1'b1, 3'd2});
    scan(48'h5_0000_0000, 0);
    chk("R2 disabled window", {hit, bounds_err}, 2'b01);
    chk("R6 miss latency", cyc, 8);
    chk("R6 miss address", xaddr, 48'h5_0000_0000);
    scan(48'h6_0000_0000, 0);
    chk("R2 above every limit", {hit, bounds_err}, 2'b01);
  endtask

  task automatic t_interleave();
    scan(48'h2_0000_1000, 0);
    chk("R3 select 1 node", {hit, node, ilog}, {1'b1, 3'd5, 2'd1});
    chk("R5 latency win1", cyc, 2);
    scan(48'h2_0000_0000, 0);
    chk("R3 select 0 node", {hit, node}, {1'b1, 3'd6});
    chk("R5 latency win2", cyc, 3);
    scan(48'h4_0000_3000, 0);
    chk("R4 mask 7", {hit, node, ilog, cfg_err}, {1'b1, 3'd4, 2'd3, 1'b0});
    chk("R8 bit34 blocks swap", xaddr, 48'h4_0000_3000);
    scan(48'h4_0000_4000, 0);
    chk("R3 select mismatch misses", {hit, bounds_err}, 2'b01);
    scan(48'h3_0000_0000, 0);
    chk("R4 bad mask", {hit, node, ilog, cfg_err}, {1'b1, 3'd3, 2'd0, 1'b1});
  endtask

  task automatic t_hole_swap();
    scan(48'h0_C000_1000, 0);
    chk("R7 in hole", {hit, bounds_err}, 2'b01);
    scan(48'h0_FFFF_FFFF, 0);
    chk("R7 hole top", {hit, bounds_err}, 2'b01);
    scan(48'h0_BFFF_F000, 0);
    chk("R7 below hole", {hit, bounds_err, node}, {2'b10, 3'd1});
    chk("R8 outside region", xaddr, 48'h0_BFFF_F000);
    scan(48'h0_1234_5678, 0);
    chk("R8 in base..limit", xaddr, 48'h0_0234_5678);
    scan(48'h0_1800_0000, 0);
    chk("R8 at region limit", xaddr, 48'h0_0800_0000);
    scan(48'h0_0800_0000, 0);
    chk("R8 below size", xaddr, 48'h0_1800_0000);
    scan(48'h0_4000_0000, 0);
    chk("R8 not in region", xaddr, 48'h0_4000_0000);
  endtask

  task automatic t_busy_start();
    scan(48'h4_0000_3000, 1);
    chk("R9 ignored start latency", cyc, 6);
    chk("R9 ignored start result", {hit, node}, {1'b1, 3'd4});
    strobe_drop("R9 no second result");
  endtask

  task automatic t_high_word();
    prog(6, 48'h100_0000_0000, 48'h100_FFFF_FFFF, 2'd1, 3'd0, 3'd0, 3'd7);
    scan(48'h100_0000_0000, 0);
    chk("R1 high words node", {hit, node}, {1'b1, 3'd7});
    chk("R5 latency win6", cyc, 7);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cfg_we = 0; cfg_kind = 0; cfg_idx = 0; cfg_wdata = 0;
    start = 0; addr = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    prog(0, 48'h1_0000_0000, 48'h1_FFFF_FFFF, 2'd3, 3'd0, 3'd0, 3'd2);
    prog(1, 48'h2_0000_0000, 48'h2_FFFF_FFFF, 2'd1, 3'd1, 3'd1, 3'd5);
    prog(2, 48'h2_0000_0000, 48'h2_FFFF_FFFF, 2'd1, 3'd1, 3'd0, 3'd6);
    prog(3, 48'h0_0000_0000, 48'h0_FFFF_FFFF, 2'd1, 3'd0, 3'd0, 3'd1);
    prog(4, 48'h3_0000_0000, 48'h3_0FFF_FFFF, 2'd2, 3'd5, 3'd0, 3'd3);
    prog(5, 48'h4_0000_0000, 48'h4_FFFF_FFFF, 2'd1, 3'd7, 3'd3, 3'd4);
    prog(6, 48'h5_0000_0000, 48'h5_FFFF_FFFF, 2'd0, 3'd0, 3'd0, 3'd7);
    prog(7, 48'h1_0000_0000, 48'h1_FFFF_FFFF, 2'd1, 3'd0, 3'd0, 3'd0);
    wr(3'd4, 3'd1, 32'hC000_0001);
    wr(3'd5, 3'd1, {1'b0, 7'd2, 1'b0, 7'd3, 1'b0, 7'd2, 7'b0, 1'b1});
    wr(3'd5, 3'd4, {1'b0, 7'h7F, 1'b0, 7'd8, 1'b0, 7'd8, 7'b0, 1'b1});
    t_basic();
    t_interleave();
    t_hole_swap();
    t_busy_start();
    t_high_word();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule